// File: doc/BRIEF.md
# Quasi-Bidirectional Port Pin Controller

This block drives a byte-wide group of quasi-bidirectional pads that have no direction register. Each pad has one output latch bit. A latch bit at 0 pulls the pad low hard and keeps it low. A latch bit at 1 leaves only a weak pull-up on, so an external source can pull the pad low and the pad works as an input. When a bit is written as 1, a strong pull-up is switched on so that a heavily loaded pad rises quickly. That boost stays on until the companion serial bus interface reports the next falling edge of its serial clock.

The latch is written through a push-only port: `wr_vld` is high for one cycle with the new byte on `wr_data`. The block accepts a byte in every cycle, so there is no ready signal and no back-pressure. The bus interface raises `wr_vld` only after it has received and acknowledged a complete byte. The pad levels pass through a two-stage synchronizer and come back on `rd_data`, where the bus interface reads them. Everything runs in one system clock domain. `por` is a synchronous power-on reset pulse.

Top module: `qb_port_ctrl`

## Requirements
- R1: In the cycle after `por` is high, every latch bit is 1. `pd_en` is 8'h00, `wpu_en` is 8'hFF, `spu_en` is 8'h00 and `rd_data` is 8'hFF.
- R2: For each bit, the latch value is 1 when `wpu_en` is 1 and `pd_en` is 0, and 0 when `pd_en` is 1 and `wpu_en` is 0. So `wpu_en` is always the bitwise inverse of `pd_en`.
- R3: In the cycle after `wr_vld` is high, the latch equals the `wr_data` of that cycle, so `pd_en` equals its inverse. In every other case the latch keeps its value, including when `scl_fall` is high.
- R4: In the cycle after a write, `spu_en` equals the written byte. Every bit written as 1 starts a boost, even if it was already 1. Every bit written as 0 ends any boost it had.
- R5: In the cycle after `scl_fall` is high without a write, `spu_en` is 8'h00. With no write and no `scl_fall`, `spu_en` keeps its value.
- R6: When `wr_vld` and `scl_fall` are high in the same cycle, the write wins and `spu_en` equals the written byte.
- R7: On no bit are `spu_en` and `pd_en` both 1 at the same time.
- R8: `rd_data` equals `pad_in` delayed by exactly two clock cycles. The latch contents do not affect it.
- R9: When `por` and `wr_vld` are high in the same cycle, the reset wins and the state is the one given in R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por | input | 1 | Synchronous power-on reset pulse, active high |
| wr_vld | input | 1 | One-cycle strobe: load `wr_data` into the latch |
| wr_data | input | 8 | New latch byte, bit i controls pad i |
| scl_fall | input | 1 | One-cycle pulse: the serial clock had a falling edge |
| pad_in | input | 8 | Pad input levels, may be asynchronous |
| pd_en | output | 8 | Strong pull-down enable per pad |
| wpu_en | output | 8 | Weak pull-up enable per pad |
| spu_en | output | 8 | Strong pull-up (boost) enable per pad |
| rd_data | output | 8 | Synchronized pad levels for reads |

## Verification
The assertions assume the following about the inputs:
- `por`, `wr_vld`, `wr_data` and `scl_fall` change only in step with `clk`.
- Only `pad_in` may arrive without relation to the clock.
- The design has seen one `por` before anything is checked.

The bench meets these assumptions. It changes every input on the falling clock edge and holds `por` high at the start. It checks outputs on the following falling edge, one rising edge after the stimulus. It checks `rd_data` two rising edges after a change on `pad_in`. It gives the cases of a write colliding with a clock-fall pulse and a reset colliding with a write their own cycles.

// File: rtl/qb_pkg.sv
package qb_pkg;

  // Number of flip-flop stages between the pads and the read data.
  localparam int unsigned QB_SYNC_DEPTH = 2;

  // Next-state operation for the boost (strong pull-up) registers.
  typedef enum logic [1:0] {
    BST_HOLD  = 2'd0,
    BST_LOAD  = 2'd1,
    BST_DROP  = 2'd2,
    BST_CLEAR = 2'd3
  } qb_bst_op_e;

endpackage

// File: rtl/qb_latch_bank.sv
module qb_latch_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         por,
  input  logic         wr_vld,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] latch_q
);

  // Power-on sets every latch bit to 1. A reset in the same cycle as a
  // write overrides the write.
  always_ff @(posedge clk) begin
    if (por) begin
      latch_q <= '1;
    end else if (wr_vld) begin
      latch_q <= wr_data;
    end
  end

endmodule

// File: rtl/qb_boost_ctrl.sv
module qb_boost_ctrl
  import qb_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         por,
  input  logic         wr_vld,
  input  logic [W-1:0] wr_data,
  input  logic         scl_fall,
  output logic [W-1:0] boost_q
);

  qb_bst_op_e op;

  // Priority, highest first: reset, then write, then clock fall, then hold.
  // A write in the same cycle as a clock fall starts a new boost.
  always_comb begin
    if (por)           op = BST_CLEAR;
    else if (wr_vld)   op = BST_LOAD;
    else if (scl_fall) op = BST_DROP;
    else               op = BST_HOLD;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      case (op)
        BST_CLEAR: boost_q[i] <= 1'b0;
        BST_LOAD:  boost_q[i] <= wr_data[i];
        BST_DROP:  boost_q[i] <= 1'b0;
        default:   boost_q[i] <= boost_q[i];
      endcase
    end
  end

endmodule

// File: rtl/qb_pad_sync.sv
module qb_pad_sync #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         por,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_sync
);

  localparam int unsigned LAST = DEPTH - 1;

  logic [W-1:0] stage [DEPTH];

  // After reset the stages hold all ones, the level of idle pads.
  always_ff @(posedge clk) begin
    if (por) begin
      for (int s = 0; s < int'(DEPTH); s++) stage[s] <= '1;
    end else begin
      stage[0] <= pad_in;
      for (int s = 1; s < int'(DEPTH); s++) stage[s] <= stage[s-1];
    end
  end

  assign pad_sync = stage[LAST];

endmodule

// File: rtl/qb_pad_drive.sv
module qb_pad_drive #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] latch_q,
  input  logic [W-1:0] boost_q,
  output logic [W-1:0] pd_en,
  output logic [W-1:0] wpu_en,
  output logic [W-1:0] spu_en
);

  for (genvar i = 0; i < W; i++) begin : g_pad
    always_comb begin
      pd_en[i]  = (latch_q[i] == 1'b0);
      wpu_en[i] = (latch_q[i] == 1'b1);
      spu_en[i] = boost_q[i];
    end
  end

endmodule

// File: rtl/qb_port_ctrl.sv
module qb_port_ctrl
  import qb_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         por,
  input  logic         wr_vld,
  input  logic [W-1:0] wr_data,
  input  logic         scl_fall,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pd_en,
  output logic [W-1:0] wpu_en,
  output logic [W-1:0] spu_en,
  output logic [W-1:0] rd_data
);

  logic [W-1:0] latch_q;
  logic [W-1:0] boost_q;

  qb_latch_bank #(.W(W)) u_latch (
    .clk     (clk),
    .por     (por),
    .wr_vld  (wr_vld),
    .wr_data (wr_data),
    .latch_q (latch_q)
  );

  qb_boost_ctrl #(.W(W)) u_boost (
    .clk      (clk),
    .por      (por),
    .wr_vld   (wr_vld),
    .wr_data  (wr_data),
    .scl_fall (scl_fall),
    .boost_q  (boost_q)
  );

  qb_pad_drive #(.W(W)) u_drive (
    .latch_q (latch_q),
    .boost_q (boost_q),
    .pd_en   (pd_en),
    .wpu_en  (wpu_en),
    .spu_en  (spu_en)
  );

  qb_pad_sync #(.W(W), .DEPTH(QB_SYNC_DEPTH)) u_sync (
    .clk      (clk),
    .por      (por),
    .pad_in   (pad_in),
    .pad_sync (rd_data)
  );

endmodule

// File: rtl/qb_port_ctrl_chk.sv
module qb_port_ctrl_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         por,
  input logic         wr_vld,
  input logic [W-1:0] wr_data,
  input logic         scl_fall,
  input logic [W-1:0] pad_in,
  input logic [W-1:0] pd_en,
  input logic [W-1:0] wpu_en,
  input logic [W-1:0] spu_en,
  input logic [W-1:0] rd_data
);

  logic       armed = 1'b0;
  logic [1:0] age   = 2'd0;

  always_ff @(posedge clk) begin
    if (por) begin
      armed <= 1'b1;
      age   <= 2'd0;
    end else if (age != 2'd3) begin
      age <= age + 2'd1;
    end
  end

  // R1 R9
  reset_state_chk: assert property (@(posedge clk)
    por |=> (pd_en == '0 && wpu_en == '1 && spu_en == '0 && rd_data == '1));

  // R2
  pull_pair_chk: assert property (@(posedge clk) disable iff (por || !armed)
    wpu_en == ~pd_en);

  // R3
  latch_load_chk: assert property (@(posedge clk) disable iff (por || !armed)
    wr_vld |=> pd_en == ~$past(wr_data));

  // R3
  latch_hold_chk: assert property (@(posedge clk) disable iff (por || !armed)
    !wr_vld |=> $stable(pd_en));

  // R4 R6
  boost_load_chk: assert property (@(posedge clk) disable iff (por || !armed)
    wr_vld |=> spu_en == $past(wr_data));

  // R5
  boost_drop_chk: assert property (@(posedge clk) disable iff (por || !armed)
    (scl_fall && !wr_vld) |=> spu_en == '0);

  // R5
  boost_hold_chk: assert property (@(posedge clk) disable iff (por || !armed)
    (!scl_fall && !wr_vld) |=> $stable(spu_en));

  // R7
  no_fight_chk: assert property (@(posedge clk) disable iff (por || !armed)
    (spu_en & pd_en) == '0);

  // R8
  sync_delay_chk: assert property (@(posedge clk) disable iff (por || !armed)
    (age >= 2'd2) |-> rd_data == $past(pad_in, 2));

endmodule

bind qb_port_ctrl qb_port_ctrl_chk #(.W(W)) u_chk (.*);

// File: tb/qb_port_ctrl_tb.sv
`timescale 1ns/1ps
module qb_port_ctrl_tb;

  logic       clk = 1'b0;
  logic       por;
  logic       wr_vld;
  logic [7:0] wr_data;
  logic       scl_fall;
  logic [7:0] pad_in;
  logic [7:0] pd_en, wpu_en, spu_en, rd_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  qb_port_ctrl u_dut (
    .clk      (clk),
    .por      (por),
    .wr_vld   (wr_vld),
    .wr_data  (wr_data),
    .scl_fall (scl_fall),
    .pad_in   (pad_in),
    .pd_en    (pd_en),
    .wpu_en   (wpu_en),
    .spu_en   (spu_en),
    .rd_data  (rd_data)
  );

  // Fields: {wr_vld, wr_data, scl_fall, expected pd_en, expected spu_en}
  localparam int NV = 10;
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 8'hA5, 1'b0, 8'h5A, 8'hA5},  // R4 write starts boost
    {1'b0, 8'h00, 1'b0, 8'h5A, 8'hA5},  // R3 R5 idle holds
    {1'b0, 8'h00, 1'b1, 8'h5A, 8'h00},  // R5 clock fall ends boost
    {1'b1, 8'h0F, 1'b0, 8'hF0, 8'h0F},  // R4
    {1'b1, 8'h0F, 1'b1, 8'hF0, 8'h0F},  // R6 rewrite of 1s with clock fall
    {1'b0, 8'h00, 1'b1, 8'hF0, 8'h00},  // R5
    {1'b1, 8'h3C, 1'b0, 8'hC3, 8'h3C},  // R4
    {1'b1, 8'h00, 1'b0, 8'hFF, 8'h00},  // R4 zeros end boost
    {1'b1, 8'hFF, 1'b0, 8'h00, 8'hFF},  // R4
    {1'b0, 8'h00, 1'b1, 8'h00, 8'h00}   // R5
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    por = 1'b1; wr_vld = 1'b0; wr_data = 8'h00; scl_fall = 1'b0; pad_in = 8'hFF;
    tick();
    tick();
    por = 1'b0;
    // R1 reset state
    check("R1 pd_en", pd_en, 8'h00);
    check("R1 wpu_en", wpu_en, 8'hFF);
    check("R1 spu_en", spu_en, 8'h00);
    check("R1 rd_data", rd_data, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      wr_vld   = VEC[i][25];
      wr_data  = VEC[i][24:17];
      scl_fall = VEC[i][16];
      tick();
      check("R3 pd_en", pd_en, VEC[i][15:8]);
      check("R2 wpu_en", wpu_en, ~VEC[i][15:8]);
      check("R4 R5 R6 spu_en", spu_en, VEC[i][7:0]);
      check("R7 no overlap", spu_en & pd_en, 8'h00);
    end
    wr_vld = 1'b0; scl_fall = 1'b0;

    // R5 clock fall without boost does nothing; R3 latch unaffected
    scl_fall = 1'b1;
    tick();
    scl_fall = 1'b0;
    check("R5 spu_en idle", spu_en, 8'h00);
    check("R3 pd_en after scl_fall", pd_en, 8'h00);

    // R8 two-cycle synchronizer latency
    pad_in = 8'h5A;
    tick();
    check("R8 rd_data after 1", rd_data, 8'hFF);
    tick();
    check("R8 rd_data after 2", rd_data, 8'h5A);

    // R8 latch does not affect read data
    wr_vld = 1'b1; wr_data = 8'hF0;
    tick();
    wr_vld = 1'b0;
    check("R4 spu_en before reset", spu_en, 8'hF0);
    check("R8 rd_data with latch", rd_data, 8'h5A);

    // R9 reset beats a write in the same cycle, also ends boost
    por = 1'b1; wr_vld = 1'b1; wr_data = 8'h00;
    tick();
    por = 1'b0; wr_vld = 1'b0;
    check("R9 pd_en", pd_en, 8'h00);
    check("R9 wpu_en", wpu_en, 8'hFF);
    check("R9 spu_en", spu_en, 8'h00);
    check("R1 rd_data reset", rd_data, 8'hFF);
    tick();
    tick();
    check("R8 rd_data after reset", rd_data, 8'h5A);

    finish_run();
  end

endmodule